// File: doc/BRIEF.md
# Cartridge DMA Request/Acknowledge Engine

This block moves data from a cartridge-side ROM to the host over a shared parallel bus, using a request/acknowledge handshake. Software on the host first loads a starting ROM word address and a transfer length through a small configuration port, then arms the engine. The engine raises its DMA request, and the host's DMA controller answers by pulling the active-low acknowledge low. While acknowledge is low, every read-strobe pulse on the bus carries exactly one 16-bit word, and the ROM address steps forward by one word after each pulse.

The length is given in blocks of 32 bytes (16 words per block). Once the last word has gone out, the engine drops its request and raises an interrupt. The interrupt stays high until software clears it. A length of zero completes at once: the engine raises the interrupt without ever raising the request.

On the ROM side, the engine fetches one word ahead into a single holding register. It does this through a valid/ready request stream (a word address) and a valid/ready response stream (the data). The ROM may hold back either stream at any time. A held request stays valid with an unchanged address until it is taken. A response is only accepted while the engine shows it is waiting for one, and the engine never has more than one fetch in flight. The engine also drives the enable for the upper byte-lane bus transceiver.

Top module: `dma_hs_engine`

## Requirements
- R1: The first ROM word address of a transfer is {offset-high register, offset-low register}. The low 16 bits are written at configuration address 0, and the upper ROM_AW-16 bits at address 1.
- R2: A write to configuration address 2 sets the length in 32-byte blocks, so a transfer moves exactly 16 x length words.
- R3: A write to configuration address 3 with data bit 0 set arms the engine. With a nonzero length, dreq is high after the clock edge that takes the write. Arming again while a transfer is running has no effect on its length or its data.
- R4: bus_oe is high only while dack_n is low, rd_n is low and a transfer is running. While bus_oe is low, bus_data is zero.
- R5: Each read pulse taken with dack_n low (rd_n low, then back high) transfers one word. The word shown during the pulse is the ROM word at the start address plus the number of words already transferred, and the address carries across the 16-bit boundary.
- R6: At the clock edge that takes the rising rd_n of the last word, dreq falls and irq rises.
- R7: Arming with a length of zero sets irq at the clock edge that takes the write, and dreq stays low.
- R8: irq stays high until a write to configuration address 3 with data bit 1 set.
- R9: A read pulse with dack_n high, or with no transfer running, drives nothing and moves neither the word count nor the address.
- R10: hi_lane_en is high exactly when rd_n is low and either dack_n or cs_n is low.
- R11: While rom_req_valid is high and rom_req_ready is low, rom_req_valid stays high and rom_req_addr is unchanged on the next cycle. The next word is fetched only after the held one has been taken.
- R12: After reset, dreq, irq, bus_oe and rom_req_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| dack_n | input | 1 | Host DMA acknowledge, active low |
| rd_n | input | 1 | Host read strobe, active low |
| cs_n | input | 1 | Host register-access chip select, active low |
| dreq | output | 1 | DMA request to the host |
| irq | output | 1 | Completion interrupt, held until cleared |
| bus_data | output | DATA_W | Word driven toward the host |
| bus_oe | output | 1 | Output enable for bus_data |
| hi_lane_en | output | 1 | Upper byte-lane transceiver enable |
| rom_req_valid | output | 1 | ROM fetch request valid |
| rom_req_ready | input | 1 | ROM accepts the fetch request |
| rom_req_addr | output | ROM_AW | ROM word address of the fetch |
| rom_rsp_valid | input | 1 | ROM response data valid |
| rom_rsp_ready | output | 1 | Engine can take a response |
| rom_rsp_data | input | DATA_W | ROM response word |

## Verification
The main path is driven with three patterns:
- A one-block transfer from an address inside a 64K word page shows that the start address and the 16-words-per-block scaling are right.
- A two-block transfer that starts eight words below a 64K boundary shows whether the address carry reaches the upper register. During it, the bench also re-arms the engine and sends a pulse with dack_n high, which shows whether such pulses are wrongly counted.
- A transfer where the ROM withholds ready on alternate cycles separates prefetch correctness from handshake timing. Here a held request must keep its address until it is taken.

Zero-length arming and strobes with no transfer running mark the edges of the request logic.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  // configuration register selects
  localparam logic [1:0] RA_OFS_LO = 2'd0;
  localparam logic [1:0] RA_OFS_HI = 2'd1;
  localparam logic [1:0] RA_COUNT  = 2'd2;
  localparam logic [1:0] RA_CTRL   = 2'd3;
  // control register bits
  localparam int CTRL_ARM_BIT = 0;
  localparam int CTRL_CLR_BIT = 1;
  // one length unit is 32 bytes = 16 words
  localparam int UNIT_WORDS_LOG2 = 4;
endpackage

// File: rtl/dma_hs_regs.sv
module dma_hs_regs
  import dma_hs_pkg::*;
#(
  parameter int ROM_AW = 20,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic [ROM_AW-1:0] start_addr,
  output logic [CNT_W-1:0]  blk_count,
  output logic              arm_pulse,
  output logic              clr_pulse
);
  localparam int HI_W = ROM_AW - 16;

  logic [15:0]     ofs_lo_q;
  logic [HI_W-1:0] ofs_hi_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_lo_q <= '0;
      ofs_hi_q <= '0;
      cnt_q    <= '0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        RA_OFS_LO: ofs_lo_q <= cfg_wdata;
        RA_OFS_HI: ofs_hi_q <= cfg_wdata[HI_W-1:0];
        RA_COUNT:  cnt_q    <= cfg_wdata[CNT_W-1:0];
        default:   ;
      endcase
    end
  end

  assign start_addr = {ofs_hi_q, ofs_lo_q};
  assign blk_count  = cnt_q;
  assign arm_pulse  = cfg_wr && (cfg_addr == RA_CTRL) && cfg_wdata[CTRL_ARM_BIT];
  assign clr_pulse  = cfg_wr && (cfg_addr == RA_CTRL) && cfg_wdata[CTRL_CLR_BIT];
endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
  import dma_hs_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int TW   = CNT_W + UNIT_WORDS_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_pulse,
  input  logic             clr_pulse,
  input  logic [CNT_W-1:0] blk_count,
  input  logic             consume,
  output logic             active,
  output logic             irq,
  output logic             load,
  output logic [TW-1:0]    total_words
);
  logic [TW-1:0] left_q;
  logic          active_q, irq_q;
  logic          zero_done, last_word, done_evt;

  assign total_words = {blk_count, {UNIT_WORDS_LOG2{1'b0}}};
  assign load        = arm_pulse && !active_q && (total_words != '0);
  assign zero_done   = arm_pulse && !active_q && (total_words == '0);
  assign last_word   = consume && active_q && (left_q == TW'(1));
  assign done_evt    = zero_done || last_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q   <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      left_q   <= total_words;
      active_q <= 1'b1;
    end else if (consume && active_q) begin
      left_q <= left_q - TW'(1);
      if (last_word) active_q <= 1'b0;
    end
  end

  // a completion in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq_q <= 1'b0;
    else if (done_evt)  irq_q <= 1'b1;
    else if (clr_pulse) irq_q <= 1'b0;
  end

  assign active = active_q;
  assign irq    = irq_q;
endmodule

// File: rtl/dma_hs_fetch.sv
module dma_hs_fetch
  import dma_hs_pkg::*;
#(
  parameter int ROM_AW = 20,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  localparam int TW    = CNT_W + UNIT_WORDS_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ROM_AW-1:0] start_addr,
  input  logic [TW-1:0]     total_words,
  input  logic              consume,
  output logic              hold_valid,
  output logic [DATA_W-1:0] hold_data,
  output logic              rom_req_valid,
  input  logic              rom_req_ready,
  output logic [ROM_AW-1:0] rom_req_addr,
  input  logic              rom_rsp_valid,
  output logic              rom_rsp_ready,
  input  logic [DATA_W-1:0] rom_rsp_data
);
  logic [ROM_AW-1:0] addr_q;
  logic [TW-1:0]     fleft_q;
  logic              pend_q, hv_q;
  logic [DATA_W-1:0] hd_q;

  assign rom_req_valid = (fleft_q != '0) && !hv_q && !pend_q;
  assign rom_req_addr  = addr_q;
  assign rom_rsp_ready = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      fleft_q <= '0;
      pend_q  <= 1'b0;
      hv_q    <= 1'b0;
      hd_q    <= '0;
    end else if (load) begin
      addr_q  <= start_addr;
      fleft_q <= total_words;
      pend_q  <= 1'b0;
      hv_q    <= 1'b0;
    end else begin
      if (rom_req_valid && rom_req_ready) begin
        pend_q  <= 1'b1;
        addr_q  <= addr_q + ROM_AW'(1);
        fleft_q <= fleft_q - TW'(1);
      end
      if (rom_rsp_valid && pend_q) begin
        pend_q <= 1'b0;
        hv_q   <= 1'b1;
        hd_q   <= rom_rsp_data;
      end
      if (consume) hv_q <= 1'b0;
    end
  end

  assign hold_valid = hv_q;
  assign hold_data  = hd_q;
endmodule

// File: rtl/dma_hs_strobe.sv
module dma_hs_strobe #(
  parameter int DATA_W    = 16,
  parameter int IN_SYNC   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dack_n,
  input  logic              rd_n,
  input  logic              cs_n,
  input  logic              active,
  input  logic              hold_valid,
  input  logic [DATA_W-1:0] hold_data,
  output logic              consume,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_data,
  output logic              hi_lane_en
);
  logic dack_s, rd_s, cs_s;
  logic rd_prev_q;

  generate
    if (IN_SYNC > 0) begin : g_sync
      logic [IN_SYNC-1:0] dack_sr, rd_sr, cs_sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dack_sr <= '1;
          rd_sr   <= '1;
          cs_sr   <= '1;
        end else begin
          for (int k = 0; k < IN_SYNC; k++) begin
            dack_sr[k] <= (k == 0) ? dack_n : dack_sr[(k == 0) ? 0 : k-1];
            rd_sr[k]   <= (k == 0) ? rd_n   : rd_sr[(k == 0) ? 0 : k-1];
            cs_sr[k]   <= (k == 0) ? cs_n   : cs_sr[(k == 0) ? 0 : k-1];
          end
        end
      end
      assign dack_s = dack_sr[IN_SYNC-1];
      assign rd_s   = rd_sr[IN_SYNC-1];
      assign cs_s   = cs_sr[IN_SYNC-1];
    end else begin : g_direct
      assign dack_s = dack_n;
      assign rd_s   = rd_n;
      assign cs_s   = cs_n;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_prev_q <= 1'b1;
    else        rd_prev_q <= rd_s;
  end

  // a word leaves when the strobe ends with acknowledge still low
  assign consume    = !rd_prev_q && rd_s && !dack_s && active && hold_valid;
  assign bus_oe     = !dack_s && !rd_s && active;
  assign bus_data   = bus_oe ? hold_data : '0;
  assign hi_lane_en = !rd_s && (!dack_s || !cs_s);
endmodule

// File: rtl/dma_hs_engine.sv
module dma_hs_engine
  import dma_hs_pkg::*;
#(
  parameter int ROM_AW  = 20,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 8,
  parameter int IN_SYNC = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [15:0]       cfg_wdata,
  input  logic              dack_n,
  input  logic              rd_n,
  input  logic              cs_n,
  output logic              dreq,
  output logic              irq,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_oe,
  output logic              hi_lane_en,
  output logic              rom_req_valid,
  input  logic              rom_req_ready,
  output logic [ROM_AW-1:0] rom_req_addr,
  input  logic              rom_rsp_valid,
  output logic              rom_rsp_ready,
  input  logic [DATA_W-1:0] rom_rsp_data
);
  localparam int TW = CNT_W + UNIT_WORDS_LOG2;

  logic [ROM_AW-1:0] start_addr;
  logic [CNT_W-1:0]  blk_count;
  logic              arm_pulse, clr_pulse, load, active, consume, hold_valid;
  logic [TW-1:0]     total_words;
  logic [DATA_W-1:0] hold_data;

  dma_hs_regs #(.ROM_AW(ROM_AW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start_addr(start_addr), .blk_count(blk_count),
    .arm_pulse(arm_pulse), .clr_pulse(clr_pulse)
  );

  dma_hs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm_pulse(arm_pulse), .clr_pulse(clr_pulse),
    .blk_count(blk_count), .consume(consume), .active(active), .irq(irq),
    .load(load), .total_words(total_words)
  );

  dma_hs_fetch #(.ROM_AW(ROM_AW), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr),
    .total_words(total_words), .consume(consume), .hold_valid(hold_valid),
    .hold_data(hold_data), .rom_req_valid(rom_req_valid),
    .rom_req_ready(rom_req_ready), .rom_req_addr(rom_req_addr),
    .rom_rsp_valid(rom_rsp_valid), .rom_rsp_ready(rom_rsp_ready),
    .rom_rsp_data(rom_rsp_data)
  );

  dma_hs_strobe #(.DATA_W(DATA_W), .IN_SYNC(IN_SYNC)) u_strobe (
    .clk(clk), .rst_n(rst_n), .dack_n(dack_n), .rd_n(rd_n), .cs_n(cs_n),
    .active(active), .hold_valid(hold_valid), .hold_data(hold_data),
    .consume(consume), .bus_oe(bus_oe), .bus_data(bus_data),
    .hi_lane_en(hi_lane_en)
  );

  assign dreq = active;
endmodule

// File: rtl/dma_hs_checker.sv
module dma_hs_checker
  import dma_hs_pkg::*;
#(
  parameter int ROM_AW = 20,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [1:0]        cfg_addr,
  input logic [15:0]       cfg_wdata,
  input logic              dack_n,
  input logic              rd_n,
  input logic              dreq,
  input logic              irq,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_oe,
  input logic              hi_lane_en,
  input logic              rom_req_valid,
  input logic              rom_req_ready,
  input logic [ROM_AW-1:0] rom_req_addr
);
  logic clr_wr;
  assign clr_wr = cfg_wr && (cfg_addr == RA_CTRL) && cfg_wdata[CTRL_CLR_BIT];

  p_oe_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!dack_n && !rd_n && dreq));

  p_quiet_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_data == '0));

  p_end_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dreq) |-> irq);

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq);

  p_lane_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hi_lane_en |-> !rd_n);

  p_req_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_req_valid && !rom_req_ready) |=> (rom_req_valid && $stable(rom_req_addr)));
endmodule

bind dma_hs_engine dma_hs_checker #(.ROM_AW(ROM_AW), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .dack_n(dack_n), .rd_n(rd_n), .dreq(dreq), .irq(irq),
  .bus_data(bus_data), .bus_oe(bus_oe), .hi_lane_en(hi_lane_en),
  .rom_req_valid(rom_req_valid), .rom_req_ready(rom_req_ready),
  .rom_req_addr(rom_req_addr)
);

// File: tb/dma_hs_engine_bench.sv
module dma_hs_engine_bench;
  localparam int AW = 20;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic dack_n = 1'b1, rd_n = 1'b1, cs_n = 1'b1;
  logic dreq, irq, bus_oe, hi_lane_en;
  logic [DW-1:0] bus_data;
  logic rom_req_valid, rom_req_ready, rom_rsp_ready;
  logic [AW-1:0] rom_req_addr;
  logic rom_rsp_valid = 1'b0;
  logic [DW-1:0] rom_rsp_data = '0;

  int total = 0, bad = 0;
  bit rom_hold = 0, rom_toggle = 0;

  always #5 clk = ~clk;

  dma_hs_engine u_dma_hs_engine (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .dack_n(dack_n), .rd_n(rd_n), .cs_n(cs_n),
    .dreq(dreq), .irq(irq), .bus_data(bus_data), .bus_oe(bus_oe),
    .hi_lane_en(hi_lane_en), .rom_req_valid(rom_req_valid),
    .rom_req_ready(rom_req_ready), .rom_req_addr(rom_req_addr),
    .rom_rsp_valid(rom_rsp_valid), .rom_rsp_ready(rom_rsp_ready),
    .rom_rsp_data(rom_rsp_data)
  );

  function automatic logic [DW-1:0] rom_word(input logic [AW-1:0] a);
    return a[15:0] ^ {12'h000, a[19:16]} ^ 16'h5A3C;
  endfunction

  // ROM model: answers one cycle after a request is taken
  logic rdy_r = 1'b1;
  assign rom_req_ready = rdy_r;
  initial begin
    bit taken = 0;
    bit phase = 0;
    logic [AW-1:0] taken_addr = '0;
    forever begin
      @(negedge clk);
      rom_rsp_valid = taken;
      rom_rsp_data  = taken ? rom_word(taken_addr) : '0;
      phase = !phase;
      rdy_r = !rom_hold && (!rom_toggle || phase);
      taken = rom_req_valid && rdy_r;
      taken_addr = rom_req_addr;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse(input bit expect_drive, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    rd_n = 1'b0;
    repeat (2) @(negedge clk);
    check(bus_oe == expect_drive, req, bus_oe, expect_drive);
    check(bus_data == (expect_drive ? exp : '0), req, bus_data, expect_drive ? exp : '0);
    @(negedge clk);
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // program, arm, run all words; optionally poke at one word index
  task automatic run_xfer(input logic [AW-1:0] ofs, input int blocks, input int poke_at);
    int n = blocks * 16;
    cfg_write(2'd0, ofs[15:0]);                   // R1
    cfg_write(2'd1, {12'h000, ofs[19:16]});       // R1
    cfg_write(2'd2, 16'(blocks));                 // R2
    cfg_write(2'd3, 16'h0001);
    check(dreq == 1'b1, "R3 dreq after arm", dreq, 1);
    repeat (4) @(negedge clk);
    dack_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i == poke_at) begin
        cfg_write(2'd3, 16'h0001);                // R3 re-arm while busy ignored
        dack_n = 1'b1;
        pulse(1'b0, '0, "R9 pulse without dack");
        dack_n = 1'b0;
      end
      pulse(1'b1, rom_word(ofs + AW'(i)), "R5 word data");
      if (i == n - 2) check(dreq == 1'b1, "R6 dreq held before last", dreq, 1);
    end
    check(dreq == 1'b0, "R6 dreq dropped", dreq, 0);
    check(irq == 1'b1, "R6 irq raised", irq, 1);
    dack_n = 1'b1;
    pulse(1'b0, '0, "R9 pulse after end");
  endtask

  task automatic clear_irq();
    repeat (3) @(negedge clk);
    check(irq == 1'b1, "R8 irq held", irq, 1);
    cfg_write(2'd3, 16'h0002);
    check(irq == 1'b0, "R8 irq cleared", irq, 0);
  endtask

  task automatic t_reset();
    check(dreq == 1'b0, "R12 dreq", dreq, 0);
    check(irq == 1'b0, "R12 irq", irq, 0);
    check(bus_oe == 1'b0, "R12 bus_oe", bus_oe, 0);
    check(rom_req_valid == 1'b0, "R12 rom_req_valid", rom_req_valid, 0);
  endtask

  task automatic t_one_block();
    run_xfer(20'h1_2340, 1, -1);                  // R1 R2 R5 R6
    clear_irq();
  endtask

  task automatic t_carry_and_poke();
    run_xfer(20'h0_FFF8, 2, 5);                   // R3 R5 R9
    clear_irq();
  endtask

  task automatic t_zero_len();
    cfg_write(2'd2, 16'h0000);
    cfg_write(2'd3, 16'h0001);
    check(irq == 1'b1, "R7 irq on zero length", irq, 1);
    check(dreq == 1'b0, "R7 no dreq", dreq, 0);
    repeat (3) @(negedge clk);
    check(dreq == 1'b0, "R7 dreq stays low", dreq, 0);
    clear_irq();
  endtask

  task automatic t_idle_and_lane();
    dack_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b0;
    @(negedge clk);
    check(bus_oe == 1'b0, "R9 idle pulse no drive", bus_oe, 0);
    check(bus_data == '0, "R4 idle data zero", bus_data, 0);
    check(hi_lane_en == 1'b1, "R10 lane on dack+rd", hi_lane_en, 1);
    rd_n = 1'b1; dack_n = 1'b1;
    @(negedge clk);
    check(hi_lane_en == 1'b0, "R10 lane off", hi_lane_en, 0);
    cs_n = 1'b0;
    @(negedge clk);
    check(hi_lane_en == 1'b0, "R10 cs without rd", hi_lane_en, 0);
    rd_n = 1'b0;
    @(negedge clk);
    check(hi_lane_en == 1'b1, "R10 lane on cs+rd", hi_lane_en, 1);
    check(bus_oe == 1'b0, "R4 cs access no drive", bus_oe, 0);
    rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_backpressure();
    rom_hold = 1;
    cfg_write(2'd0, 16'h0400);
    cfg_write(2'd1, 16'h0003);
    cfg_write(2'd2, 16'h0001);
    cfg_write(2'd3, 16'h0001);
    repeat (2) @(negedge clk);
    check(rom_req_valid == 1'b1, "R11 request held", rom_req_valid, 1);
    check(rom_req_addr == 20'h3_0400, "R11 held addr", rom_req_addr, 20'h3_0400);
    repeat (3) @(negedge clk);
    check(rom_req_addr == 20'h3_0400, "R11 addr stable", rom_req_addr, 20'h3_0400);
    rom_hold = 0;
    rom_toggle = 1;
    dack_n = 1'b0;
    for (int i = 0; i < 16; i++)
      pulse(1'b1, rom_word(20'h3_0400 + AW'(i)), "R11 data under stall");
    check(irq == 1'b1, "R6 irq after stalled run", irq, 1);
    dack_n = 1'b1;
    rom_toggle = 0;
    clear_irq();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_one_block();
    t_carry_and_poke();
    t_zero_len();
    t_idle_and_lane();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule